// File: doc/BRIEF.md
# Manchester II Serial Word Transmitter

This block turns one 16-bit word into the serial waveform of a dual-redundant command/response avionics bus. Each word starts with a three-bit-time sync pattern, continues with the 16 payload bits and ends with an odd parity bit. The payload and parity are Manchester II encoded at 1 Mbit/s. The sync is not a Manchester pattern: it holds one level for 1.5 bit times and the opposite level for the next 1.5 bit times. The sync polarity marks the word as either a command/status word or a data word.

A word is offered on a valid/ready handshake, together with a flag that selects the sync type. The block drives a pair of complementary line signals and a drive-enable for an external transceiver. When nothing is being sent, all three outputs are low.

Words of one message can follow each other with no dead time between them. To do this, the next word is offered while the current one is still being sent. The block accepts it on the last cycle of the current parity bit.

Top module: `mtx_word_tx`

## Requirements
- R1: Each payload and parity bit cell lasts 16 clock cycles. A 1 is sent as 8 cycles with `line_pos` high, then 8 cycles low. A 0 is sent as low, then high. There is always a level change in the middle of the cell.
- R2: With `in_is_cmd`=1, the sync is 24 cycles with `line_pos` high, then 24 cycles low. With `in_is_cmd`=0, the sync is 24 cycles low, then 24 cycles high.
- R3: After the sync, the 16 payload bits go out most significant bit first. Bit 15 takes cycles 48..63 of the word and bit 0 takes cycles 288..303.
- R4: The parity bit takes cycles 304..319 of the word. Its value makes the number of ones across the payload and parity odd.
- R5: A word drives the line for exactly 320 cycles, starting with the first cycle after the accepting clock edge. If no new word is accepted, the drive-enable then drops.
- R6: While `drive_en` is high, `line_neg` is the complement of `line_pos`. While it is low, both line signals are low.
- R7: A word accepted on the final cycle of the current word starts its sync on the very next cycle, with no idle cycle between the two words.
- R8: `busy` is high from the cycle after acceptance through the last cycle of the parity bit. While busy, `in_ready` is low except on that last cycle.
- R9: After reset, `busy`, `drive_en`, `line_pos` and `line_neg` are low, and `in_ready` is high.
- R10: `in_valid` raised during a word, before its last cycle, is ignored. The word being sent is not altered, and no further word follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-timing clock, 16 cycles per bit cell |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The block can take a word this cycle |
| in_data | input | 16 | Payload word |
| in_is_cmd | input | 1 | 1 selects command/status sync, 0 selects data sync |
| line_pos | output | 1 | True line drive |
| line_neg | output | 1 | Complement line drive |
| drive_en | output | 1 | Transceiver drive enable |
| busy | output | 1 | A word is being sent |

## Verification
The line output of a word is due starting with the first cycle after the accepting edge. From there, each of its 320 levels is due one cycle after the previous one. The bench pushes the full expected level sequence of each word into a queue when it offers the word. A monitor samples on the falling edge and pops one level for each cycle in which `drive_en` is high. In this way, every level is compared in its own cycle, and the bench needs no separate latency constant. The monitor also checks two timing-dependent results against its own count of the position within the word: `in_ready` must be high only at position 319, and the length of each unbroken drive run must be 320 cycles, or 640 cycles for a chained pair.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  // One Manchester II cell as {first half, second half}
  function automatic logic [1:0] mcell(input logic b);
    return {b, ~b};
  endfunction

  // Line level of the leading sync half for a given sync type
  function automatic logic sync_lead(input logic is_cmd);
    return is_cmd;
  endfunction

endpackage

// File: rtl/mtx_slot_timer.sv
module mtx_slot_timer #(
  parameter int HALF_CYC = 8,
  parameter int NSLOT    = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic slot_end,
  output logic word_end,
  output logic [$clog2(NSLOT)-1:0] slot_idx
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int SW = $clog2(NSLOT);

  logic [CW-1:0] cnt;
  logic [SW-1:0] slot;

  assign slot_end = run && (cnt == CW'(HALF_CYC - 1));
  assign word_end = slot_end && (slot == SW'(NSLOT - 1));
  assign slot_idx = slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      slot <= '0;
    end else if (start) begin
      cnt  <= '0;
      slot <= '0;
    end else if (run) begin
      if (slot_end) begin
        cnt  <= '0;
        slot <= word_end ? '0 : slot + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mtx_pattern_reg.sv
module mtx_pattern_reg #(
  parameter int DATA_W  = 16,
  parameter int SYNC_HB = 3,
  parameter int NSLOT   = 2 * SYNC_HB + 2 * (DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] data,
  input  logic              is_cmd,
  output logic              head
);
  import mtx_pkg::*;

  logic [NSLOT-1:0] pat;
  logic [NSLOT-1:0] sreg;
  logic             par;

  // Odd parity over payload plus parity bit
  assign par = ~(^data);

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_HB; gi++) begin : g_sync
      assign pat[NSLOT-1-gi]         = sync_lead(is_cmd);
      assign pat[NSLOT-1-SYNC_HB-gi] = ~sync_lead(is_cmd);
    end
    for (gi = 0; gi < DATA_W; gi++) begin : g_bits
      assign pat[NSLOT-1-2*SYNC_HB-2*gi -: 2] = mcell(data[DATA_W-1-gi]);
    end
  endgenerate
  assign pat[1:0] = mcell(par);

  always_ff @(posedge clk) begin
    if (!rst_n)
      sreg <= '0;
    else if (load)
      sreg <= pat;
    else if (shift)
      sreg <= {sreg[NSLOT-2:0], 1'b0};
  end

  assign head = sreg[NSLOT-1];

endmodule

// File: rtl/mtx_word_tx.sv
module mtx_word_tx #(
  parameter int HALF_CYC = 8,
  parameter int DATA_W   = 16,
  parameter int SYNC_HB  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_is_cmd,
  output logic              line_pos,
  output logic              line_neg,
  output logic              drive_en,
  output logic              busy
);
  localparam int NSLOT = 2 * SYNC_HB + 2 * (DATA_W + 1);
  localparam int SW    = $clog2(NSLOT);

  logic          active;
  logic          accept;
  logic          slot_end;
  logic          word_end;
  logic [SW-1:0] slot_idx;
  logic          head;

  assign in_ready = !active || word_end;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)
      active <= 1'b0;
    else if (accept)
      active <= 1'b1;
    else if (word_end)
      active <= 1'b0;
  end

  mtx_slot_timer #(.HALF_CYC(HALF_CYC), .NSLOT(NSLOT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .run      (active),
    .slot_end (slot_end),
    .word_end (word_end),
    .slot_idx (slot_idx)
  );

  mtx_pattern_reg #(.DATA_W(DATA_W), .SYNC_HB(SYNC_HB), .NSLOT(NSLOT)) u_pat (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .shift  (slot_end),
    .data   (in_data),
    .is_cmd (in_is_cmd),
    .head   (head)
  );

  assign line_pos = active & head;
  assign line_neg = active & ~head;
  assign drive_en = active;
  assign busy     = active;

  // Line pair complementary while driven
  assert_complement_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> (line_pos != line_neg));
  assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> (!line_pos && !line_neg));
  // Mid-cell transition inside every payload/parity cell
  assert_midbit_flip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && !word_end && (int'(slot_idx) >= 2 * SYNC_HB) && !slot_idx[0])
      |=> (line_pos != $past(line_pos)));
  // Sync level flat within each half, flips between halves
  assert_sync_flat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && (int'(slot_idx) != SYNC_HB - 1) && (int'(slot_idx) < 2 * SYNC_HB - 1))
      |=> $stable(line_pos));
  assert_sync_turn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && (int'(slot_idx) == SYNC_HB - 1)) |=> (line_pos != $past(line_pos)));
  // Busy and handshake
  assert_busy_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  assert_ready_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !word_end) |-> !in_ready);
  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_end && !accept) |=> !busy);
  assert_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_end && accept) |=> drive_en);

endmodule

// File: tb/sim_mtx_word_tx.sv
module sim_mtx_word_tx;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, in_valid, in_ready, in_is_cmd;
  logic [15:0] in_data;
  logic        line_pos, line_neg, drive_en, busy;

  mtx_word_tx u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_is_cmd(in_is_cmd), .line_pos(line_pos),
    .line_neg(line_neg), .drive_en(drive_en), .busy(busy)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit exp_q[$];
  int pos      = 0;
  int run_len  = 0;
  int last_run = 0;
  bit mon_on   = 0;
  bit prev_lv  = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected per-cycle line levels of one word
  task automatic push_word(logic [15:0] d, bit cmd);
    int ones = 0;
    bit p;
    for (int i = 0; i < 24; i++) exp_q.push_back(cmd);
    for (int i = 0; i < 24; i++) exp_q.push_back(!cmd);
    for (int b = 15; b >= 0; b--) begin
      if (d[b]) ones++;
      for (int i = 0; i < 8; i++) exp_q.push_back(d[b]);
      for (int i = 0; i < 8; i++) exp_q.push_back(!d[b]);
    end
    p = (ones % 2 == 0);
    for (int i = 0; i < 8; i++) exp_q.push_back(p);
    for (int i = 0; i < 8; i++) exp_q.push_back(!p);
  endtask

  task automatic send(logic [15:0] d, bit cmd);
    push_word(d, cmd);
    @(negedge clk);
    in_data = d; in_is_cmd = cmd; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      string req;
      bit e;
      if (drive_en)
        chk(line_neg == !line_pos, "R6", "line_neg vs ~line_pos", line_neg, !line_pos);
      else
        chk(!line_pos && !line_neg, "R6", "idle line pair", {line_pos, line_neg}, 0);
      chk(busy == drive_en, "R8", "busy vs drive", busy, drive_en);
      if (drive_en) begin
        if (exp_q.size() == 0) begin
          chk(0, "R5", "drive with no word due", 1, 0);
        end else begin
          e = exp_q.pop_front();
          req = (pos < 48) ? "R2" : ((pos < 304) ? "R3" : "R4");
          chk(line_pos == e, req, $sformatf("level at word cycle %0d", pos), line_pos, e);
          if (pos >= 48 && ((pos - 48) % 16 == 8))
            chk(line_pos != prev_lv, "R1", "mid-cell transition", line_pos, !prev_lv);
          chk(in_ready == (pos == 319), "R8", $sformatf("in_ready at cycle %0d", pos),
              in_ready, (pos == 319));
          pos = (pos + 1) % 320;
        end
        prev_lv = line_pos;
        run_len++;
      end else if (run_len != 0) begin
        last_run = run_len;
        run_len  = 0;
        chk(pos == 0, "R5", "word cut short at position", pos, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_is_cmd = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy, "R9", "busy after reset", busy, 0);
    chk(!drive_en, "R9", "drive_en after reset", drive_en, 0);
    chk(!line_pos && !line_neg, "R9", "line pair after reset", {line_pos, line_neg}, 0);
    chk(in_ready, "R9", "in_ready after reset", in_ready, 1);
    rst_n = 1'b1;
    mon_on = 1'b1;

    send(16'hA5C3, 1'b1); wait_idle();
    chk(last_run == 320, "R5", "single word length", last_run, 320);
    send(16'h0000, 1'b0); wait_idle();
    chk(last_run == 320, "R5", "zero word length", last_run, 320);
    send(16'hFFFF, 1'b1); wait_idle();
    chk(last_run == 320, "R4", "all-ones word length", last_run, 320);
    send(16'h0001, 1'b0); wait_idle();
    chk(last_run == 320, "R3", "lsb word length", last_run, 320);

    // Chained pair
    send(16'h1234, 1'b1);
    send(16'h8001, 1'b0);
    wait_idle();
    chk(last_run == 640, "R7", "chained drive run", last_run, 640);

    // Offer during a word, withdrawn before its last cycle
    send(16'h5A5A, 1'b1);
    repeat (100) @(negedge clk);
    in_data = 16'hFFFF; in_is_cmd = 1'b0; in_valid = 1'b1;
    for (int i = 0; i < 40; i++) begin
      chk(!in_ready, "R10", "in_ready during word", in_ready, 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    wait_idle();
    chk(last_run == 320, "R10", "no extra word after ignored offer", last_run, 320);
    chk(exp_q.size() == 0, "R10", "pending expected levels", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule